// File: doc/BRIEF.md
# Eight-bit tick counter with shared power-of-two prescaler

The block is an 8-bit up-counter. It advances on one of two sources. The first is a one-cycle pulse from the system instruction clock. The second is an edge on an external input, which is first synchronised to the system clock. A single prescaler can divide the counter's source by a power of two. That prescaler is shared: one control bit gives it either to this counter or to the watchdog tick path. The side that does not own the prescaler runs undivided.

Software reaches three registers over a small write-strobe bus with a combinational read port.

| Address | Register | Contents |
|---------|----------|----------|
| 0 | Count | Current count value |
| 1 | Control | Source, edge, prescaler assignment and ratio |
| 2 | Interrupt | Sticky overflow flag and the two interrupt enables |

When the count rolls over from all ones to zero, the overflow flag is set and counting carries on. The interrupt output is the flag gated by a local enable and a global enable. Software clears the flag by writing it to 0.

Top module: `pscl_counter`

## Requirements
- R1: After reset the count reads 0x00, the control register reads 0x3F, the interrupt register reads 0x00 and irq_o is low.
- R2: Control bit 5 = 0 selects the instruction tick. With control bit 3 = 1 (prescaler given to the watchdog), the count rises by one on the clock edge that samples tick_int_i high.
- R3: With control bit 3 = 0, ratio code k in control bits 2:0 makes the count rise once per 2^(k+1) source ticks, from 1:2 for code 0 up to 1:256 for code 7.
- R4: Control bit 5 = 1 selects ext_pin_i. It passes through a two-flop synchroniser. With control bit 4 = 0, each low-to-high transition adds exactly one to the count.
- R5: With control bit 4 = 1, each high-to-low transition of ext_pin_i adds one, and rising transitions add nothing.
- R6: When the count advances from 0xFF, it becomes 0x00 and the overflow flag (bit 0 of address 2) is set. Later ticks keep counting.
- R7: irq_o is high only when all three of the following are set: the flag, the local enable (bit 1 of address 2) and the global enable (bit 2 of address 2).
- R8: The flag stays set until a write to address 2 with bit 0 = 0. An overflow in the same cycle as that write takes priority, and the flag stays set.
- R9: A write to address 0 loads the count. The write wins over a same-cycle tick. When the prescaler belongs to the counter, the write also restarts the division.
- R10: Ticks from the source that is not selected do not change the count.
- R11: wdt_tick_o pulses once per 2^k wdt_src_i pulses while control bit 3 = 1. While control bit 3 = 0, wdt_tick_o follows wdt_src_i undivided.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int_i | input | 1 | Instruction clock tick, one cycle wide |
| ext_pin_i | input | 1 | External count input, asynchronous |
| wdt_src_i | input | 1 | Raw watchdog tick, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 = count, 1 = control, 2 = interrupt |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Overflow interrupt request |
| wdt_tick_o | output | 1 | Watchdog tick after the shared prescaler |

## Verification
A wrong prescaler count cannot be seen directly at the ports. It shows up as a count that lags or leads the expected value once a full division period has passed, so checks read the count after a whole number of periods and right after a write that restarts the division. A bad synchroniser or edge-history flop shows as a missing or doubled count three clock edges after a pin transition. A flag fault shows as a wrong value at address 2 or on irq_o on the edge of the 0xFF-to-0x00 advance, and it persists until software writes address 2.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned PS_W   = 3;
  localparam logic [1:0]  A_CNT  = 2'd0;
  localparam logic [1:0]  A_CTRL = 2'd1;
  localparam logic [1:0]  A_IRQ  = 2'd2;

  typedef struct packed {
    logic            src_ext;   // bit 5
    logic            edge_fall; // bit 4
    logic            ps_wdt;    // bit 3
    logic [PS_W-1:0] ratio;     // bits 2:0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{src_ext: 1'b1, edge_fall: 1'b1, ps_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/pscl_edge_det.sv
module pscl_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;

  assign pulse_o = fall_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/pscl_div.sv
module pscl_div #(
  parameter int unsigned CW = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [SW-1:0] shift_i,
  output logic          out_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   span;
  logic          last;

  assign span  = ({{CW{1'b0}}, 1'b1} << shift_i) - 1'b1;
  assign last  = (cnt_q == span[CW-1:0]);
  assign out_o = tick_i & last & ~clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter
  import pscl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_int_i,
  input  logic          ext_pin_i,
  input  logic          wdt_src_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wdt_tick_o
);
  localparam int unsigned SH_W = $clog2(DW + 1);

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d, ien_q, ien_d, gie_q, gie_d;
  logic          ext_pulse, src_tick, div_tick, div_out, div_clr, inc, ovf;
  logic          wr_cnt, wr_ctrl, wr_irq;
  logic [SH_W-1:0] shift;

  pscl_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
    .fall_i(ctrl_q.edge_fall), .pulse_o(ext_pulse)
  );

  assign wr_cnt  = wr_en_i && (addr_i == A_CNT);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_irq  = wr_en_i && (addr_i == A_IRQ);

  assign src_tick = ctrl_q.src_ext ? ext_pulse : tick_int_i;

  // shared prescaler: input and ratio follow its owner
  assign div_tick = ctrl_q.ps_wdt ? wdt_src_i : src_tick;
  assign shift    = ctrl_q.ps_wdt ? SH_W'(ctrl_q.ratio) : SH_W'(ctrl_q.ratio) + 1'b1;
  assign div_clr  = wr_cnt & ~ctrl_q.ps_wdt;

  pscl_div #(.CW(DW), .SW(SH_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(div_clr), .tick_i(div_tick),
    .shift_i(shift), .out_o(div_out)
  );

  assign inc        = ctrl_q.ps_wdt ? src_tick : div_out;
  assign wdt_tick_o = ctrl_q.ps_wdt ? div_out : wdt_src_i;
  assign ovf        = inc & ~wr_cnt & (cnt_q == {DW{1'b1}});

  always_comb begin
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    ien_d  = ien_q;
    gie_d  = gie_q;
    if (wr_cnt)   cnt_d = wdata_i;
    else if (inc) cnt_d = cnt_q + 1'b1;
    if (wr_ctrl)  ctrl_d = ctrl_t'(wdata_i[5:0]);
    if (wr_irq) begin
      flag_d = wdata_i[0];
      ien_d  = wdata_i[1];
      gie_d  = wdata_i[2];
    end
    if (ovf) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      ctrl_q <= CTRL_RST;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      ien_q  <= ien_d;
      gie_q  <= gie_d;
    end

  always_comb begin
    case (addr_i)
      A_CNT:   rdata_o = cnt_q;
      A_CTRL:  rdata_o = {2'b00, ctrl_q};
      A_IRQ:   rdata_o = {5'b00000, gie_q, ien_q, flag_q};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & ien_q & gie_q;
endmodule

// File: rtl/pscl_counter_chk.sv
module pscl_counter_chk
  import pscl_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] cnt_q,
  input logic          flag_q,
  input logic          inc,
  input logic          wr_cnt,
  input logic          wr_irq,
  input logic [DW-1:0] wdata_i,
  input logic          irq_o,
  input logic          wdt_tick_o,
  input logic          wdt_src_i
);
  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_cnt && cnt_q == {DW{1'b1}}) |=> (flag_q && cnt_q == '0));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R9
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata_i)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_irq) |=> flag_q);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q);

  // R11
  wdt_tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick_o |-> wdt_src_i);
endmodule

bind pscl_counter pscl_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .flag_q(flag_q), .inc(inc),
  .wr_cnt(wr_cnt), .wr_irq(wr_irq), .wdata_i(wdata_i), .irq_o(irq_o),
  .wdt_tick_o(wdt_tick_o), .wdt_src_i(wdt_src_i)
);

// File: tb/pscl_counter_bench.sv
module pscl_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_int_i = 1'b0, ext_pin_i = 1'b0, wdt_src_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o, wdt_tick_o;

  int checks = 0, failures = 0, wpulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pscl_counter u_pscl_counter (
    .clk(clk), .rst_n(rst_n), .tick_int_i(tick_int_i), .ext_pin_i(ext_pin_i),
    .wdt_src_i(wdt_src_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .wdt_tick_o(wdt_tick_o)
  );

  // vector: {ctrl, tick count, expected count}
  localparam logic [31:0] VEC [6] = '{
    {8'h08, 16'd5,   8'd5},   // R2 undivided
    {8'h00, 16'd7,   8'd3},   // R3 1:2
    {8'h01, 16'd16,  8'd4},   // R3 1:4
    {8'h02, 16'd20,  8'd2},   // R3 1:8
    {8'h07, 16'd300, 8'd1},   // R3 1:256
    {8'h08, 16'd0,   8'd0}    // R2 no ticks
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_int_i = 1'b1;
    end
    @(negedge clk); tick_int_i = 1'b0;
  endtask

  task automatic pin_cycle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin_i = 1'b1;
      repeat (4) @(negedge clk);
      ext_pin_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wdt_pulses(input int n);
    wpulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_src_i = 1'b1;
      #1 if (wdt_tick_o) wpulses++;
      @(negedge clk); wdt_src_i = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd1, v); check("R1 ctrl", v, 8'h3F);
    rd(2'd2, v); check("R1 irqreg", v, 8'h00);
    check("R1 irq_o", {7'd0, irq_o}, 8'h00);

    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][31:24]);
      wr(2'd0, 8'h00);
      if (VEC[i][23:8] != 0) ticks(int'(VEC[i][23:8]));
      rd(2'd0, v);
      check((VEC[i][31:24] == 8'h08) ? "R2 vector" : "R3 vector", v, VEC[i][7:0]);
    end

    // R4 rising edges
    wr(2'd1, 8'h28); wr(2'd0, 8'h00);
    pin_cycle(3);
    rd(2'd0, v); check("R4 rising", v, 8'd3);
    // R10 instruction ticks ignored with external source
    ticks(5);
    rd(2'd0, v); check("R10 ignored", v, 8'd3);
    // R5 falling edges
    wr(2'd1, 8'h38); wr(2'd0, 8'h00);
    @(negedge clk); ext_pin_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R5 rise no count", v, 8'd0);
    ext_pin_i = 1'b0;
    repeat (4) @(negedge clk);
    pin_cycle(2);
    rd(2'd0, v); check("R5 falling", v, 8'd3);
    // R10 pin ignored with internal source
    wr(2'd1, 8'h08); wr(2'd0, 8'h00);
    pin_cycle(2);
    rd(2'd0, v); check("R10 pin ignored", v, 8'd0);

    // R6 overflow
    wr(2'd0, 8'hFE);
    ticks(1);
    rd(2'd2, v); check("R6 no flag at FF", v, 8'h00);
    ticks(1);
    rd(2'd0, v); check("R6 wrap", v, 8'h00);
    rd(2'd2, v); check("R6 flag", v, 8'h01);
    ticks(1);
    rd(2'd0, v); check("R6 continues", v, 8'h01);
    check("R7 no enables", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h03);
    #1 check("R7 no global", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h07);
    #1 check("R7 all set", {7'd0, irq_o}, 8'h01);
    // R8 sticky across ticks
    ticks(3);
    rd(2'd2, v); check("R8 sticky", v, 8'h07);
    wr(2'd2, 8'h06);
    rd(2'd2, v); check("R8 cleared", v, 8'h06);
    check("R7 cleared irq", {7'd0, irq_o}, 8'h00);
    // R8 overflow beats same-cycle clear
    wr(2'd2, 8'h07);
    wr(2'd0, 8'hFF);
    @(negedge clk);
    tick_int_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h06;
    @(negedge clk);
    tick_int_i = 1'b0; wr_en_i = 1'b0;
    rd(2'd2, v); check("R8 set wins", v, 8'h07);

    // R9 write wins over tick, and restarts division
    wr(2'd0, 8'h00);
    @(negedge clk);
    tick_int_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h40;
    @(negedge clk);
    tick_int_i = 1'b0; wr_en_i = 1'b0;
    rd(2'd0, v); check("R9 write wins", v, 8'h40);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    ticks(1);
    wr(2'd0, 8'h10);
    ticks(1);
    rd(2'd0, v); check("R9 division restart", v, 8'h10);
    ticks(1);
    rd(2'd0, v); check("R9 after period", v, 8'h11);

    // R11 watchdog path
    wr(2'd1, 8'h0A);
    wdt_pulses(8);
    check("R11 divided 1:4", 8'(wpulses), 8'd2);
    wr(2'd1, 8'h08);
    wdt_pulses(3);
    check("R11 code0 1:1", 8'(wpulses), 8'd3);
    wr(2'd1, 8'h02);
    wdt_pulses(5);
    check("R11 undivided", 8'(wpulses), 8'd5);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule